// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Stack

This block tracks, for one processor, which interrupt is being serviced and which ones it preempted. The priority selector ahead of it presents the highest pending interrupt ID and its priority. When the processor reads the acknowledge port, the block decides whether that interrupt may preempt the one now running. If it may, the block returns its ID, asks the selector to clear its pending state, makes it the running interrupt and adopts its priority. If it may not, the block returns the spurious ID 1023 and changes nothing.

Each acknowledged interrupt records the interrupt it preempted as its predecessor, so the nesting history forms a linked chain that starts at the running ID. An end-of-interrupt (EOI) write for the running ID pops it and restores its predecessor's ID and priority. An EOI for an interrupt deeper in the chain is legal. A small walker then follows the chain one link per cycle and splices the entry out. While the walker runs it holds `busy_o` high and ignores new strobes. When the `LEGACY_REPEND` parameter is set, an EOI also re-raises a level-triggered interrupt whose line is still high, which is enabled and which targets this processor.

Top module: `irq_active_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100 (the 9-bit idle value), `busy_o` is low, and `ack_rsp_o`, `pend_clr_o` and `pend_set_o` are low.
- R2: An accepted acknowledge is rejected when the pending ID is 1023 or any other value at or above `NUM_IRQ`, or when the pending priority is not strictly below the running priority. A rejected acknowledge returns 1023 with `ack_rsp_o`, raises no `pend_clr_o` and leaves the running ID and priority unchanged.
- R3: A taken acknowledge returns the pending ID on `ack_id_o` with `ack_rsp_o` one cycle after the strobe. In the same cycle it pulses `pend_clr_o` with that ID. From that cycle on, the running ID is the new ID and the running priority is zero-extended from the pending priority.
- R4: An EOI is ignored (no state change, no `pend_set_o`, no busy) when its 10-bit ID is at or above `NUM_IRQ`, which includes 1023, or when the running ID is 1023.
- R5: An EOI whose ID equals the running ID makes the running ID and priority those of the interrupt it preempted, one cycle after the strobe. If it preempted nothing, they become 1023 and 0x100.
- R6: An EOI for an ID that is not running removes that ID from the chain without changing the running ID. Later EOIs of the running interrupts then skip over it.
- R7: An EOI for a non-running ID raises `busy_o` for exactly one cycle per link visited. Counting from the running ID, the walk ends at the link that names the target, or at the first link equal to 1023.
- R8: An acknowledge or EOI strobe presented while `busy_o` is high has no effect and gives no `ack_rsp_o`. When an acknowledge and an EOI arrive in the same cycle, the acknowledge is served and the EOI is dropped.
- R9: With `LEGACY_REPEND` set, an EOI that is not ignored pulses `pend_set_o` with its ID one cycle after the strobe, if and only if the interrupt's bits in all four of `lvl_trig_i`, `line_hi_i`, `irq_en_i` and `cpu_tgt_i` are 1.
- R10: Only bits [9:0] of `eoi_data_i` form the EOI ID. Bits [31:10] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_id_i | input | 10 | Highest pending ID from the selector (1023 = none) |
| pend_prio_i | input | 8 | Priority of the pending ID (lower value = more urgent) |
| ack_i | input | 1 | Acknowledge read strobe |
| ack_rsp_o | output | 1 | Acknowledge response valid, one cycle after an accepted strobe |
| ack_id_o | output | 10 | Acknowledge return value |
| eoi_i | input | 1 | End-of-interrupt write strobe |
| eoi_data_i | input | 32 | EOI write data; bits [9:0] hold the ID |
| lvl_trig_i | input | NUM_IRQ | Per interrupt: 1 = level-triggered |
| line_hi_i | input | NUM_IRQ | Per interrupt: input line currently high |
| irq_en_i | input | NUM_IRQ | Per interrupt: enabled |
| cpu_tgt_i | input | NUM_IRQ | Per interrupt: routed to this processor |
| busy_o | output | 1 | Chain walk in progress; strobes ignored |
| run_id_o | output | 10 | Running interrupt ID (1023 = idle) |
| run_prio_o | output | 9 | Running priority (0x100 = idle) |
| pend_clr_o | output | 1 | Request to clear a pending state |
| pend_clr_id_o | output | 10 | ID whose pending state is cleared |
| pend_set_o | output | 1 | Request to set a pending state |
| pend_set_id_o | output | 10 | ID to set pending |

## Verification
A wrong predecessor link stays hidden until the interrupt that owns it completes. It then appears as a wrong `run_id_o`/`run_prio_o` in the cycle after that EOI, or as a `busy_o` burst of the wrong length on a later out-of-order EOI. The bench therefore keeps its own model of the chain and unwinds every chain it builds, so that each stored link is brought to the ports. A wrong running priority shows at once as an acknowledge taken or rejected against the threshold. The priority sweep around the running value catches an off-by-one in that comparison at the boundary value.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int ID_W    = 10;
  localparam int PRIO_W  = 8;
  localparam int RPRIO_W = PRIO_W + 1;

  typedef logic [ID_W-1:0]    irq_id_t;
  typedef logic [PRIO_W-1:0]  prio_t;
  typedef logic [RPRIO_W-1:0] rprio_t;

  localparam irq_id_t IDLE_ID   = irq_id_t'((1 << ID_W) - 1);
  localparam rprio_t  IDLE_PRIO = rprio_t'(1 << PRIO_W);

  typedef enum logic {
    WALK_IDLE,
    WALK_STEP
  } walk_st_e;
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ       = 64,
  parameter bit LEGACY_REPEND = 1'b1
) (
  input  irq_id_t            pend_id_i,
  input  prio_t              pend_prio_i,
  input  irq_id_t            run_id_i,
  input  rprio_t             run_prio_i,
  input  logic [31:0]        eoi_data_i,
  input  logic [NUM_IRQ-1:0] lvl_trig_i,
  input  logic [NUM_IRQ-1:0] line_hi_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] cpu_tgt_i,
  output logic               ack_take_o,
  output irq_id_t            eoi_id_o,
  output logic               eoi_ok_o,
  output logic               eoi_hit_o,
  output logic               repend_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic eoi_unused;
  logic eoi_in_rng;
  logic [IDX_W-1:0] eoi_idx;

  assign eoi_unused = ^eoi_data_i[31:ID_W];

  // out-of-range pending IDs (1023 included) are never taken
  assign ack_take_o = (pend_id_i < irq_id_t'(NUM_IRQ)) &&
                      ({1'b0, pend_prio_i} < run_prio_i);

  assign eoi_id_o   = eoi_data_i[ID_W-1:0];
  assign eoi_in_rng = eoi_id_o < irq_id_t'(NUM_IRQ);
  assign eoi_ok_o   = eoi_in_rng && (run_id_i != IDLE_ID);
  assign eoi_hit_o  = eoi_id_o == run_id_i;
  assign eoi_idx    = eoi_id_o[IDX_W-1:0];

  generate
    if (LEGACY_REPEND) begin : g_repend
      assign repend_o = eoi_in_rng && lvl_trig_i[eoi_idx] && line_hi_i[eoi_idx] &&
                        irq_en_i[eoi_idx] && cpu_tgt_i[eoi_idx];
    end else begin : g_no_repend
      logic repend_unused;
      assign repend_unused = ^{lvl_trig_i, line_hi_i, irq_en_i, cpu_tgt_i, eoi_idx};
      assign repend_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/irq_link_store.sv
module irq_link_store
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    lk_we_i,
  input  irq_id_t lk_wa_i,
  input  irq_id_t lk_wd_i,
  input  logic    pr_we_i,
  input  irq_id_t pr_wa_i,
  input  rprio_t  pr_wd_i,
  input  irq_id_t ra0_i,
  output irq_id_t rd0_o,
  input  irq_id_t ra1_i,
  output irq_id_t rd1_o,
  input  irq_id_t pra_i,
  output rprio_t  prd_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  irq_id_t link_q [NUM_IRQ];
  rprio_t  prio_q [NUM_IRQ];

  function automatic logic in_rng(irq_id_t a);
    return a < irq_id_t'(NUM_IRQ);
  endfunction

  // an out-of-range address reads as end of chain / idle priority
  assign rd0_o = in_rng(ra0_i) ? link_q[ra0_i[IDX_W-1:0]] : IDLE_ID;
  assign rd1_o = in_rng(ra1_i) ? link_q[ra1_i[IDX_W-1:0]] : IDLE_ID;
  assign prd_o = in_rng(pra_i) ? prio_q[pra_i[IDX_W-1:0]] : IDLE_PRIO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        link_q[i] <= IDLE_ID;
        prio_q[i] <= IDLE_PRIO;
      end
    end else begin
      if (lk_we_i && in_rng(lk_wa_i)) link_q[lk_wa_i[IDX_W-1:0]] <= lk_wd_i;
      if (pr_we_i && in_rng(pr_wa_i)) prio_q[pr_wa_i[IDX_W-1:0]] <= pr_wd_i;
    end
  end
endmodule

// File: rtl/irq_chain_walker.sv
module irq_chain_walker
  import irq_trk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  irq_id_t head_i,
  input  irq_id_t tgt_i,
  input  irq_id_t link_cur_i,
  input  irq_id_t link_tgt_i,
  output irq_id_t cur_o,
  output irq_id_t tgt_o,
  output logic    busy_o,
  output logic    wr_o,
  output irq_id_t wr_idx_o,
  output irq_id_t wr_data_o
);
  walk_st_e st_q;
  irq_id_t  cur_q, tgt_q;
  logic     at_end, found;

  assign busy_o    = st_q == WALK_STEP;
  assign cur_o     = cur_q;
  assign tgt_o     = tgt_q;
  assign at_end    = link_cur_i == IDLE_ID;
  assign found     = !at_end && (link_cur_i == tgt_q);
  assign wr_o      = busy_o && found;
  assign wr_idx_o  = cur_q;
  assign wr_data_o = link_tgt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WALK_IDLE;
      cur_q <= IDLE_ID;
      tgt_q <= IDLE_ID;
    end else begin
      unique case (st_q)
        WALK_IDLE: if (start_i) begin
          st_q  <= WALK_STEP;
          cur_q <= head_i;
          tgt_q <= tgt_i;
        end
        WALK_STEP: begin
          if (at_end || found) st_q <= WALK_IDLE;
          else                 cur_q <= link_cur_i;
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end

  // R7
  walk_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || cur_q != $past(cur_q)));
  // R7
  walk_write_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !busy_o);
endmodule

// File: rtl/irq_active_tracker.sv
module irq_active_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ       = 64,
  parameter bit LEGACY_REPEND = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [9:0]         pend_id_i,
  input  logic [7:0]         pend_prio_i,
  input  logic               ack_i,
  output logic               ack_rsp_o,
  output logic [9:0]         ack_id_o,
  input  logic               eoi_i,
  input  logic [31:0]        eoi_data_i,
  input  logic [NUM_IRQ-1:0] lvl_trig_i,
  input  logic [NUM_IRQ-1:0] line_hi_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] cpu_tgt_i,
  output logic               busy_o,
  output logic [9:0]         run_id_o,
  output logic [8:0]         run_prio_o,
  output logic               pend_clr_o,
  output logic [9:0]         pend_clr_id_o,
  output logic               pend_set_o,
  output logic [9:0]         pend_set_id_o
);
  irq_id_t run_id_q, ack_id_q, clr_id_q, set_id_q;
  rprio_t  run_prio_q;
  logic    ack_rsp_q, clr_q, set_q;

  logic    ack_take, eoi_ok, eoi_hit, repend;
  irq_id_t eoi_id;
  logic    walk_busy, walk_wr;
  irq_id_t walk_cur, walk_tgt, walk_wr_idx, walk_wr_data;
  logic    ack_go, ack_set, eoi_go;
  irq_id_t rd0, rd1;
  rprio_t  prd;
  logic    lk_we;
  irq_id_t lk_wa, lk_wd;

  irq_req_decode #(.NUM_IRQ(NUM_IRQ), .LEGACY_REPEND(LEGACY_REPEND)) u_dec (
    .pend_id_i  (pend_id_i),
    .pend_prio_i(pend_prio_i),
    .run_id_i   (run_id_q),
    .run_prio_i (run_prio_q),
    .eoi_data_i (eoi_data_i),
    .lvl_trig_i (lvl_trig_i),
    .line_hi_i  (line_hi_i),
    .irq_en_i   (irq_en_i),
    .cpu_tgt_i  (cpu_tgt_i),
    .ack_take_o (ack_take),
    .eoi_id_o   (eoi_id),
    .eoi_ok_o   (eoi_ok),
    .eoi_hit_o  (eoi_hit),
    .repend_o   (repend)
  );

  // strobes are dropped while walking; ack wins over a same-cycle EOI
  assign ack_go  = ack_i && !walk_busy;
  assign ack_set = ack_go && ack_take;
  assign eoi_go  = eoi_i && !walk_busy && !ack_i && eoi_ok;

  assign lk_we = ack_set || walk_wr;
  assign lk_wa = ack_set ? pend_id_i : walk_wr_idx;
  assign lk_wd = ack_set ? run_id_q  : walk_wr_data;

  irq_link_store #(.NUM_IRQ(NUM_IRQ)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lk_we_i(lk_we),
    .lk_wa_i(lk_wa),
    .lk_wd_i(lk_wd),
    .pr_we_i(ack_set),
    .pr_wa_i(pend_id_i),
    .pr_wd_i({1'b0, pend_prio_i}),
    .ra0_i  (walk_busy ? walk_cur : run_id_q),
    .rd0_o  (rd0),
    .ra1_i  (walk_tgt),
    .rd1_o  (rd1),
    .pra_i  (rd0),
    .prd_o  (prd)
  );

  irq_chain_walker u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eoi_go && !eoi_hit),
    .head_i    (run_id_q),
    .tgt_i     (eoi_id),
    .link_cur_i(rd0),
    .link_tgt_i(rd1),
    .cur_o     (walk_cur),
    .tgt_o     (walk_tgt),
    .busy_o    (walk_busy),
    .wr_o      (walk_wr),
    .wr_idx_o  (walk_wr_idx),
    .wr_data_o (walk_wr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_id_q   <= IDLE_ID;
      run_prio_q <= IDLE_PRIO;
      ack_rsp_q  <= 1'b0;
      ack_id_q   <= IDLE_ID;
      clr_q      <= 1'b0;
      clr_id_q   <= IDLE_ID;
      set_q      <= 1'b0;
      set_id_q   <= IDLE_ID;
    end else begin
      ack_rsp_q <= ack_go;
      clr_q     <= ack_set;
      set_q     <= eoi_go && repend;
      if (ack_go)  ack_id_q <= ack_take ? pend_id_i : IDLE_ID;
      if (ack_set) clr_id_q <= pend_id_i;
      if (eoi_go && repend) set_id_q <= eoi_id;
      if (ack_set) begin
        run_id_q   <= pend_id_i;
        run_prio_q <= {1'b0, pend_prio_i};
      end else if (eoi_go && eoi_hit) begin
        run_id_q   <= rd0;
        run_prio_q <= prd;
      end
    end
  end

  assign ack_rsp_o     = ack_rsp_q;
  assign ack_id_o      = ack_id_q;
  assign busy_o        = walk_busy;
  assign run_id_o      = run_id_q;
  assign run_prio_o    = run_prio_q;
  assign pend_clr_o    = clr_q;
  assign pend_clr_id_o = clr_id_q;
  assign pend_set_o    = set_q;
  assign pend_set_id_o = set_id_q;

  // R1
  idle_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_id_o == IDLE_ID) |-> (run_prio_o == IDLE_PRIO));
  // R2
  reject_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && ack_id_o == IDLE_ID) |-> ($stable(run_id_o) && $stable(run_prio_o) && !pend_clr_o));
  // R3
  take_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && ack_id_o != IDLE_ID) |-> (run_id_o == ack_id_o && pend_clr_o && pend_clr_id_o == ack_id_o));
  // R8
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(run_id_o) && $stable(run_prio_o) && !ack_rsp_o && !pend_set_o));
  // R9
  set_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_set_o |-> (pend_set_id_o < irq_id_t'(NUM_IRQ)));
endmodule

// File: tb/tb_irq_active_tracker.sv
`timescale 1ns/1ps
module tb_irq_active_tracker;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   pend_id = 10'd1023;
  logic [7:0]   pend_prio = 8'hff;
  logic         ack = 1'b0;
  logic         eoi = 1'b0;
  logic [31:0]  eoi_data = '0;
  logic [N-1:0] lvl = '0, line = '0, en = '0, tgt = '0;
  logic         ack_rsp, busy, pclr, pset;
  logic [9:0]   ack_id, run_id, pclr_id, pset_id;
  logic [8:0]   run_prio;

  int n_chk = 0, n_fail = 0;
  int m_link [N];
  int m_prio [N];
  int m_run = 1023, m_rprio = 256;

  always #4 clk = ~clk;

  irq_active_tracker #(.NUM_IRQ(N), .LEGACY_REPEND(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_id_i(pend_id), .pend_prio_i(pend_prio),
    .ack_i(ack), .ack_rsp_o(ack_rsp), .ack_id_o(ack_id), .eoi_i(eoi),
    .eoi_data_i(eoi_data), .lvl_trig_i(lvl), .line_hi_i(line), .irq_en_i(en),
    .cpu_tgt_i(tgt), .busy_o(busy), .run_id_o(run_id), .run_prio_o(run_prio),
    .pend_clr_o(pclr), .pend_clr_id_o(pclr_id), .pend_set_o(pset),
    .pend_set_id_o(pset_id)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit in_chain(int id);
    int c = m_run;
    for (int k = 0; k < 64; k++) begin
      if (c == 1023) return 1'b0;
      if (c == id) return 1'b1;
      c = m_link[c];
    end
    return 1'b0;
  endfunction

  task automatic do_ack(int id, int prio);
    bit take = (id < N) && (prio < m_rprio);
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(prio); ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R3 ack_rsp", ack_rsp, 1);
    check(take ? "R3 ack_id" : "R2 ack_id", ack_id, take ? id : 1023);
    check(take ? "R3 pend_clr" : "R2 pend_clr", pclr, take);
    if (take) begin
      check("R3 pend_clr_id", pclr_id, id);
      m_link[id] = m_run; m_prio[id] = prio;
      m_run = id; m_rprio = prio;
    end
    check("R2 run_id", run_id, m_run);
    check("R2 run_prio", run_prio, m_rprio);
  endtask

  task automatic do_eoi(logic [31:0] data);
    int id = int'(data[9:0]);
    bit ok = (id < N) && (m_run != 1023);
    bit rp = ok && lvl[id % N] && line[id % N] && en[id % N] && tgt[id % N];
    int steps = 0;
    int nb;
    if (ok && id == m_run) begin
      int p = m_link[id];
      m_run = p; m_rprio = (p == 1023) ? 256 : m_prio[p];
    end else if (ok) begin
      int c = m_run;
      for (int k = 0; k < 64; k++) begin
        int nx = m_link[c];
        steps++;
        if (nx == 1023) break;
        if (nx == id) begin m_link[c] = m_link[id]; break; end
        c = nx;
      end
    end
    @(negedge clk);
    eoi_data = data; eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    check("R9 pend_set", pset, rp);
    if (rp) check("R9 pend_set_id", pset_id, id);
    nb = 0;
    while (busy && nb < 100) begin nb++; @(negedge clk); end
    check("R7 busy cycles", nb, steps);
    check(ok ? "R5 R6 run_id" : "R4 run_id", run_id, m_run);
    check(ok ? "R5 R6 run_prio" : "R4 run_prio", run_prio, m_rprio);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_link[i] = 1023; m_prio[i] = 256; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 run_id", run_id, 1023);
    check("R1 run_prio", run_prio, 256);
    check("R1 busy", busy, 0);
    check("R1 ack_rsp", ack_rsp, 0);
    check("R1 pend_clr", pclr, 0);
    check("R1 pend_set", pset, 0);

    // R4 EOI when idle, all repend conditions true
    lvl = '1; line = '1; en = '1; tgt = '1;
    do_eoi(32'd2);

    // R2 out-of-range and spurious pending IDs
    do_ack(1023, 0);
    do_ack(20, 0);

    // R2 R3 priority sweep around a running priority of 0x80
    do_ack(5, 8'h80);
    for (int p = 8'h70; p <= 8'h90; p++) begin
      do_ack(3, p);
      if (m_run == 3) do_eoi(32'd3);
    end
    do_eoi(32'd5);

    // R9 each repend condition removed in turn
    for (int k = 0; k < 5; k++) begin
      lvl = '1; line = '1; en = '1; tgt = '1;
      if (k == 1) lvl[6] = 1'b0;
      if (k == 2) line[6] = 1'b0;
      if (k == 3) en[6] = 1'b0;
      if (k == 4) tgt[6] = 1'b0;
      do_ack(6, 8'h20);
      do_eoi(32'd6);
    end
    lvl = '0;

    // R6 R7 R8 deep chain 4->3->2->1, out-of-order EOI of 1
    do_ack(1, 8'hf0); do_ack(2, 8'hc0); do_ack(3, 8'h80); do_ack(4, 8'h40);
    @(negedge clk);
    eoi_data = 32'd1; eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    check("R7 busy start", busy, 1);
    pend_id = 10'd7; pend_prio = 8'h10; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R8 ack during busy", ack_rsp, 0);
    check("R8 run during busy", run_id, 4);
    while (busy) @(negedge clk);
    m_link[2] = 1023;
    check("R6 run kept", run_id, 4);
    // R8 ack and EOI together: EOI dropped
    @(negedge clk);
    pend_id = 10'd7; pend_prio = 8'hff; ack = 1'b1; eoi_data = 32'd4; eoi = 1'b1;
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
    check("R8 ack served", ack_rsp, 1);
    check("R8 eoi dropped", run_id, 4);
    // R4 out-of-range EOI with a running interrupt
    do_eoi(32'd20);
    do_eoi(32'd1023);
    // R10 upper data bits ignored, R5 R6 unwind skipping 1
    do_eoi(32'hABCD_FC04);
    do_eoi(32'd3);
    do_eoi(32'hFFFF_FC02);
    check("R6 chain empty", run_id, 1023);

    // mixed sequence against the model
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom_range(0, 99));
      lvl = N'($urandom); line = N'($urandom); en = N'($urandom); tgt = N'($urandom);
      if (r < 50) begin
        int id = int'($urandom_range(0, N + 1));
        if (r < 4) id = 1023;
        if (id < N && in_chain(id)) id = 1023;
        do_ack(id, int'($urandom_range(0, 255)));
      end else begin
        logic [31:0] d = $urandom;
        if (r < 80 && m_run != 1023) d[9:0] = 10'(m_run);
        else d[9:0] = 10'($urandom_range(0, N + 1));
        do_eoi(d);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule